// File: doc/BRIEF.md
# Asynchronous Serial Character Transmitter

This block turns parallel characters into asynchronous serial frames on a single line that rests high. A character is handed over through a valid/ready handshake. The block then drives a low start bit and 5 to 8 data bits, least significant bit first. An optional parity bit comes next, followed by a high stop period of one, one and a half or two bit times.

All timing comes from a single-cycle tick enable that pulses at sixteen times the baud rate. The tick is generated outside the block. Every bit lasts a fixed number of ticks, so a stop period of one and a half bits is an exact count of ticks and no separate clock is needed.

The character length, parity mode and stop length are static configuration inputs. They are captured together with the character when it is accepted. While a frame is on the line, ready stays low. A character that is already waiting when the stop period ends is taken on the next clock, so its start bit follows the stop period directly.

Top module: `sertx_top`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1 and `in_ready` is 1.
- R2: A character is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle until the stop period has ended. While `in_ready` is 0, `in_valid` and `in_data` have no effect, and no extra frame appears afterwards.
- R3: In the cycle after acceptance, `txd` goes to 0 and stays 0 for 16 ticks (the start bit).
- R4: The data bits follow the start bit, least significant first, each held for 16 ticks. The count is `cfg_len` + 5 (00 gives 5 bits, 11 gives 8 bits). Bits of `in_data` above that count are not sent.
- R5: The parity mode is set by `cfg_par`. The value 01 selects even parity: one bit equal to the XOR of the sent data bits. The value 10 selects odd parity: the inverse of that XOR. The values 00 and 11 send no parity bit. A parity bit lasts 16 ticks.
- R6: The stop period holds `txd` at 1. Its length is set by `cfg_stop`: 00 gives 16 ticks, 01 gives 24 ticks, and 10 or 11 give 32 ticks.
- R7: The data and all three configuration fields are captured at acceptance. Changing any of them during a frame does not alter that frame.
- R8: If `in_valid` is 1 when the stop period ends, the new character is accepted on the next clock. Its start bit begins without a single idle tick in between.
- R9: `txd` changes only in a cycle that follows a tick or an acceptance.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Enable pulse at 16 times the baud rate |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Block can take a character |
| in_data | input | 8 | Character, bit 0 sent first |
| cfg_len | input | 2 | Data bit count minus 5 |
| cfg_par | input | 2 | Parity mode: 00/11 none, 01 even, 10 odd |
| cfg_stop | input | 2 | Stop length: 00 one bit, 01 one and a half, 10/11 two |
| txd | output | 1 | Serial line, high when idle |

## Verification
The bench compares the line against an expected stream of tick-sized slots, so an off-by-one in any bit count shows up at once. A stop counter that rounds the 1.5-bit case to 16 or 32 ticks would make the frame too short or too long. Parity folded over all eight bits, not just the sent ones, would give the wrong parity bit for a 5-bit character with high bits set. A design that reads its configuration live would corrupt a frame when the settings change in the middle of it. A design that reopens ready late would add an idle gap between back-to-back characters. Finally, the bench asserts valid with junk data during a frame: a design that latches this data would send an extra frame or mix it into the current one.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int CHAR_MAX = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } phase_t;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_OFF  = 2'b11
    } par_mode_t;

    // settings frozen at acceptance
    typedef struct packed {
        logic [3:0] nbits;
        logic       par_en;
        logic       par_bit;
        logic [1:0] stop_sel;
    } frame_cfg_t;

    function automatic logic [3:0] len_of(input logic [1:0] sel);
        return 4'd5 + {2'b00, sel};
    endfunction

    function automatic logic parity_of(input logic [CHAR_MAX-1:0] d,
                                       input logic [3:0] n,
                                       input logic odd);
        logic p;
        p = odd;
        for (int i = 0; i < CHAR_MAX; i++) begin
            if (i < int'(n)) p = p ^ d[i];
        end
        return p;
    endfunction

endpackage

// File: rtl/sertx_bitclk.sv
module sertx_bitclk #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt;

    assign wrap = tick && (cnt == limit - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= wrap ? '0 : cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/sertx_shreg.sv
module sertx_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         lsb
);
    logic [W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '1;
        end else if (load) begin
            sr <= din;
        end else if (shift) begin
            sr <= {1'b1, sr[W-1:1]};
        end
    end

    assign lsb = sr[0];
endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
    import sertx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int CNT_W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [CHAR_MAX-1:0] in_data,
    input  logic [1:0]          cfg_len,
    input  logic [1:0]          cfg_par,
    input  logic [1:0]          cfg_stop,
    input  logic                wrap,
    input  logic                lsb,
    output logic                in_ready,
    output logic                accept,
    output logic                shift,
    output logic                busy,
    output logic [CNT_W-1:0]    limit,
    output logic                txd
);
    localparam logic [CNT_W-1:0] LIM_ONE  = CNT_W'(OSR);
    localparam logic [CNT_W-1:0] LIM_HALF = CNT_W'(OSR + OSR / 2);
    localparam logic [CNT_W-1:0] LIM_TWO  = CNT_W'(2 * OSR);

    phase_t     ph;
    logic [2:0] idx;
    frame_cfg_t fc;
    frame_cfg_t fc_new;
    par_mode_t  pm;

    assign pm       = par_mode_t'(cfg_par);
    assign in_ready = (ph == PH_IDLE);
    assign busy     = (ph != PH_IDLE);
    assign accept   = in_valid && in_ready;
    assign shift    = wrap && (ph == PH_DATA);

    always_comb begin
        fc_new.nbits    = len_of(cfg_len);
        fc_new.par_en   = (pm == PAR_EVEN) || (pm == PAR_ODD);
        fc_new.par_bit  = parity_of(in_data, fc_new.nbits, pm == PAR_ODD);
        fc_new.stop_sel = cfg_stop;
    end

    always_comb begin
        if (ph == PH_STOP) begin
            case (fc.stop_sel)
                2'b00:   limit = LIM_ONE;
                2'b01:   limit = LIM_HALF;
                default: limit = LIM_TWO;
            endcase
        end else begin
            limit = LIM_ONE;
        end
    end

    always_comb begin
        case (ph)
            PH_START: txd = 1'b0;
            PH_DATA:  txd = lsb;
            PH_PAR:   txd = fc.par_bit;
            default:  txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PH_IDLE;
            idx <= '0;
            fc  <= '0;
        end else if (accept) begin
            ph  <= PH_START;
            idx <= '0;
            fc  <= fc_new;
        end else if (wrap) begin
            case (ph)
                PH_START: begin
                    ph  <= PH_DATA;
                    idx <= '0;
                end
                PH_DATA: begin
                    if ({1'b0, idx} == fc.nbits - 4'd1) begin
                        ph <= fc.par_en ? PH_PAR : PH_STOP;
                    end else begin
                        idx <= idx + 3'd1;
                    end
                end
                PH_PAR:  ph <= PH_STOP;
                default: ph <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [CHAR_MAX-1:0] in_data,
    input  logic [1:0]          cfg_len,
    input  logic [1:0]          cfg_par,
    input  logic [1:0]          cfg_stop,
    output logic                txd
);
    localparam int CNT_W = $clog2(2 * OSR + 1);

    logic             accept;
    logic             shift;
    logic             busy;
    logic             wrap;
    logic             lsb;
    logic [CNT_W-1:0] limit;
    logic             tick_act;

    assign tick_act = tick && busy;

    sertx_bitclk #(.CNT_W(CNT_W)) u_bitclk (
        .clk   (clk),
        .rst   (rst),
        .clr   (accept),
        .tick  (tick_act),
        .limit (limit),
        .wrap  (wrap)
    );

    sertx_shreg #(.W(CHAR_MAX)) u_shreg (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .shift (shift),
        .din   (in_data),
        .lsb   (lsb)
    );

    sertx_ctrl #(.OSR(OSR), .CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .cfg_len  (cfg_len),
        .cfg_par  (cfg_par),
        .cfg_stop (cfg_stop),
        .wrap     (wrap),
        .lsb      (lsb),
        .in_ready (in_ready),
        .accept   (accept),
        .shift    (shift),
        .busy     (busy),
        .limit    (limit),
        .txd      (txd)
    );
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic in_valid,
    input logic in_ready,
    input logic txd
);
    // R1
    r1_idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> txd);

    // R3
    r3_start_low_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !txd);

    // R2
    r2_busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R2
    r2_ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(in_ready) |-> $past(tick));

    // R9
    r9_line_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(txd) |-> ($past(tick) || $past(in_valid && in_ready)));
endmodule

bind sertx_top sertx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .txd      (txd)
);

// File: tb/tb_sertx_top.sv
`timescale 1ns/1ps
module tb_sertx_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic [1:0] cfg_len = 2'b11;
    logic [1:0] cfg_par = 2'b00;
    logic [1:0] cfg_stop = 2'b00;
    logic       in_ready;
    logic       txd;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    bit exp_bits [0:1023];
    int exp_n = 0;

    sertx_top dut (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .cfg_len  (cfg_len),
        .cfg_par  (cfg_par),
        .cfg_stop (cfg_stop),
        .txd      (txd)
    );

    always #2 clk = ~clk;

    initial begin
        forever begin
            repeat (3) @(posedge clk);
            tick <= 1'b1;
            @(posedge clk);
            tick <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic push(input bit v, input int n);
        for (int k = 0; k < n; k++) begin
            exp_bits[exp_n] = v;
            exp_n++;
        end
    endtask

    // pmode: 0 none, 1 even, 2 odd
    task automatic add_frame(input logic [7:0] d, input int nb, input int pmode, input int stop_ticks);
        bit p;
        push(1'b0, 16);
        p = (pmode == 2);
        for (int b = 0; b < nb; b++) begin
            push(d[b], 16);
            p = p ^ d[b];
        end
        if (pmode == 1 || pmode == 2) push(p, 16);
        push(1'b1, stop_ticks);
    endtask

    // called at the negedge right after the accepting edge
    task automatic check_stream(input string tag);
        int  bad_idx = -1;
        int  bad_act = 0;
        int  bad_exp = 0;
        bit  rdy_bad = 1'b0;
        int  i = 0;
        while (i < exp_n) begin
            if (tick) begin
                if (txd !== exp_bits[i] && bad_idx < 0) begin
                    bad_idx = i;
                    bad_act = int'(txd);
                    bad_exp = int'(exp_bits[i]);
                end
                if (in_ready !== 1'b0) rdy_bad = 1'b1;
                i++;
            end
            if (i < exp_n) @(negedge clk);
        end
        check(bad_idx < 0, $sformatf("%s line at tick %0d", tag, bad_idx), bad_act, bad_exp);
        check(!rdy_bad, {tag, " R2 ready low during frame"}, int'(rdy_bad), 0);
        exp_n = 0;
    endtask

    task automatic offer(input logic [7:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic idle_check(input string tag, input int n_ticks);
        int bad = 0;
        int i = 0;
        @(negedge clk);
        while (i < n_ticks) begin
            if (txd !== 1'b1 || in_ready !== 1'b1) bad++;
            if (tick) i++;
            @(negedge clk);
        end
        check(bad == 0, tag, bad, 0);
    endtask

    task automatic t_reset();
        check(txd === 1'b1, "R1 txd after reset", int'(txd), 1);
        check(in_ready === 1'b1, "R1 ready after reset", int'(in_ready), 1);
    endtask

    task automatic t_8n1();
        cfg_len = 2'b11; cfg_par = 2'b00; cfg_stop = 2'b00;
        add_frame(8'hA5, 8, 0, 16);
        offer(8'hA5);
        in_valid = 1'b0;
        check_stream("R3 R4 R6 8 bits no parity one stop");
        idle_check("R1 idle after frame", 3);
    endtask

    task automatic t_5e15();
        cfg_len = 2'b00; cfg_par = 2'b01; cfg_stop = 2'b01;
        add_frame(8'hF3, 5, 1, 24);
        offer(8'hF3);
        in_valid = 1'b0;
        check_stream("R4 R5 R6 5 bits even 1.5 stop");
    endtask

    task automatic t_7o2();
        cfg_len = 2'b10; cfg_par = 2'b10; cfg_stop = 2'b10;
        add_frame(8'h5C, 7, 2, 32);
        offer(8'h5C);
        in_valid = 1'b0;
        check_stream("R4 R5 R6 7 bits odd two stop");
    endtask

    task automatic t_6x2();
        cfg_len = 2'b01; cfg_par = 2'b11; cfg_stop = 2'b11;
        add_frame(8'hEA, 6, 0, 32);
        offer(8'hEA);
        in_valid = 1'b0;
        check_stream("R4 R5 R6 6 bits parity off stop 11");
    endtask

    task automatic t_cfg_hold();
        cfg_len = 2'b11; cfg_par = 2'b00; cfg_stop = 2'b00;
        add_frame(8'h81, 8, 0, 16);
        offer(8'h81);
        in_valid = 1'b0;
        fork
            check_stream("R7 config change mid frame");
            begin
                repeat (20) @(negedge clk);
                cfg_len = 2'b00; cfg_par = 2'b10; cfg_stop = 2'b10;
                in_data = 8'h00;
            end
        join
        cfg_len = 2'b11; cfg_par = 2'b00; cfg_stop = 2'b00;
    endtask

    task automatic t_ignore();
        cfg_len = 2'b11; cfg_par = 2'b00; cfg_stop = 2'b00;
        add_frame(8'h3C, 8, 0, 16);
        offer(8'h3C);
        in_valid = 1'b0;
        fork
            check_stream("R2 valid while busy");
            begin
                repeat (10) @(negedge clk);
                in_valid = 1'b1;
                in_data  = 8'h00;
                repeat (100) @(negedge clk);
                in_valid = 1'b0;
            end
        join
        idle_check("R2 no extra frame after busy valid", 40);
    endtask

    task automatic t_b2b();
        cfg_len = 2'b11; cfg_par = 2'b01; cfg_stop = 2'b00;
        add_frame(8'h96, 8, 1, 16);
        add_frame(8'h0F, 8, 1, 16);
        offer(8'h96);
        in_data = 8'h0F;
        fork
            check_stream("R8 back to back");
            begin
                @(negedge clk);
                while (!in_ready) @(negedge clk);
                @(negedge clk);
                in_valid = 1'b0;
            end
        join
        idle_check("R1 idle after back to back", 3);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_8n1();
        t_5e15();
        t_7o2();
        t_6x2();
        t_cfg_hold();
        t_ignore();
        t_b2b();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog all requirements actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule